// File: doc/BRIEF.md
# Power-Aware Peripheral Clock Prescaler

This block is a free-running binary divider chain driven by the system clock. Peripherals on the chip share it. Each peripheral has its own tap-select code, which picks one bit of the chain. For each peripheral the block produces a single-cycle clock-enable strobe every time the selected bit goes from 0 to 1. In effect, every peripheral gets its own power-of-two division of the chain's advance rate.

A three-bit power-mode code tells the block how the system clock is being used. In the four low-power modes where the system clock halts, the chain is held cleared and every strobe stays low. In full-speed active mode the chain advances on every clock. In medium-speed active mode and in sleep mode, a pre-divider sits in front of the chain. A two-bit ratio field slows the chain to one step per 16, 32, 64 or 128 clocks. Software cannot read or load the count.

Top module: `clkpre_top`

## Requirements
- R1: The chain is CNT_W bits wide (13 by default). It increases by exactly one on every enabled advance and wraps from all ones to zero.
- R2: While rst is high the count is zero and all strobes are low. The first advance happens on the first clock edge after rst falls, so in full-speed mode a tap with select code 0 pulses in the first cycle after release.
- R3: Power-mode codes 3 (standby), 4 (watch), 5 (subclock active), 6 (subclock sleep) and the reserved code 7 stop the chain. Each of these codes clears the count to zero and holds it there, and keeps every strobe low.
- R4: Power-mode code 0 (full-speed active) advances the chain on every clock.
- R5: Power-mode codes 1 (medium-speed active) and 2 (sleep) advance the chain once every 16 << med_ratio clocks. Ratio codes 0, 1, 2 and 3 therefore give 16, 32, 64 and 128.
- R6: A new med_ratio value is taken up only when the pre-divider reaches its terminal count. The interval already in progress finishes at the old ratio.
- R7: Each tap has its own select code k, taken from tap_sel bits [4p+3:4p] for tap p. For 0 <= k < CNT_W, the tap pulses whenever chain bit k rises, which is once per 2^(k+1) advances. Taps do not affect each other.
- R8: A strobe is a registered pulse one clock wide. It is high in the cycle in which the selected bit first reads 1.
- R9: A select code of CNT_W or more produces no strobe.
- R10: When the mode returns from a stopped mode to a running mode, counting restarts from zero. A tap with select code k first pulses after 2^k advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mode | input | 3 | Power-mode code (0 full, 1 medium, 2 sleep, 3..7 stopped) |
| med_ratio | input | 2 | Medium-speed division code (16 << code) |
| tap_sel | input | N_TAPS*SEL_W | Per-tap bit-select codes, tap p at [SEL_W*p +: SEL_W] |
| tap_strobe | output | N_TAPS | Per-tap single-cycle clock-enable strobes |

## Verification
The bench keeps the default 13-bit chain with four taps and four-bit select codes. With these values the top tap (code 12) pulses and the chain wraps within a full-speed run of about nine thousand clocks. Select codes 13 to 15 can then be driven to show that out-of-range codes stay silent. The four pre-divider ratios are also short enough to measure strobe gaps at the medium-speed rates and to switch the ratio part-way through an interval.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

    typedef enum logic [2:0] {
        PM_RUN_FULL  = 3'd0,
        PM_RUN_MED   = 3'd1,
        PM_SLEEP     = 3'd2,
        PM_STANDBY   = 3'd3,
        PM_WATCH     = 3'd4,
        PM_SUB_RUN   = 3'd5,
        PM_SUB_SLEEP = 3'd6,
        PM_RESERVED  = 3'd7
    } pwr_mode_e;

    localparam int RATIO_W   = 2;
    localparam int BASE_LOG2 = 4;
    localparam int PD_W      = BASE_LOG2 + (1 << RATIO_W) - 1;

    typedef struct packed {
        logic adv;
        logic stopped;
    } step_t;

    function automatic logic clock_stopped(pwr_mode_e m);
        return (m >= PM_STANDBY);
    endfunction

    function automatic logic uses_prediv(pwr_mode_e m);
        return (m == PM_RUN_MED) || (m == PM_SLEEP);
    endfunction

    function automatic logic [PD_W-1:0] prediv_last(logic [RATIO_W-1:0] r);
        return (PD_W'(1 << BASE_LOG2) << r) - PD_W'(1);
    endfunction

endpackage

// File: rtl/clkpre_prediv.sv
module clkpre_prediv
    import clkpre_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  pwr_mode_e          mode,
    input  logic [RATIO_W-1:0] ratio_in,
    output step_t              step
);

    logic [PD_W-1:0]    pd_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               at_last;
    logic               stopped;

    always_comb begin
        stopped  = clock_stopped(mode);
        at_last  = (pd_q == prediv_last(ratio_q));
        step.stopped = stopped;
        step.adv     = !stopped && ((mode == PM_RUN_FULL) || at_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q    <= '0;
            ratio_q <= '0;
        end else if (!uses_prediv(mode) || at_last) begin
            pd_q    <= '0;
            ratio_q <= ratio_in;
        end else begin
            pd_q    <= pd_q + PD_W'(1);
        end
    end

    AST_PD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pd_q <= prediv_last(ratio_q)); // R5

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
        (uses_prediv(mode) && !at_last) |=> $stable(ratio_q)); // R6

    AST_STOP_NO_ADV: assert property (@(posedge clk) disable iff (rst)
        clock_stopped(mode) |-> !step.adv); // R3

endmodule

// File: rtl/clkpre_chain.sv
module clkpre_chain
    import clkpre_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    output logic [CNT_W-1:0] rise
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        rise    = step.adv ? (~cnt_q & cnt_inc) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || step.stopped) begin
            cnt_q <= '0;
        end else if (step.adv) begin
            cnt_q <= cnt_inc;
        end
    end

    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (rst)
        step.stopped |=> (cnt_q == '0)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!step.stopped && step.adv) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!step.stopped && !step.adv) |=> $stable(cnt_q)); // R5

    AST_ONE_RISE: assert property (@(posedge clk) disable iff (rst)
        step.adv |-> $countones(rise) == 1 || cnt_q == '1); // R1

endmodule

// File: rtl/clkpre_tap.sv
module clkpre_tap
    import clkpre_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stopped,
    input  logic [CNT_W-1:0] rise,
    input  logic [SEL_W-1:0] sel,
    output logic             strobe_q
);

    localparam int EXT_W = 1 << SEL_W;
    localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(CNT_W);

    logic [EXT_W-1:0] rise_ext;
    logic             sel_ok;
    logic             fire;

    always_comb begin
        rise_ext = EXT_W'(rise);
        sel_ok   = ({1'b0, sel} < SEL_LIMIT);
        fire     = !stopped && sel_ok && rise_ext[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= fire;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && sel == $past(sel)) |=> !strobe_q); // R8

    AST_BAD_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel_ok |=> !strobe_q); // R9

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        stopped |=> !strobe_q); // R3

endmodule

// File: rtl/clkpre_top.sv
module clkpre_top
    import clkpre_pkg::*;
#(
    parameter int CNT_W  = 13,
    parameter int N_TAPS = 4,
    parameter int SEL_W  = $clog2(CNT_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              pwr_mode,
    input  logic [RATIO_W-1:0]      med_ratio,
    input  logic [N_TAPS*SEL_W-1:0] tap_sel,
    output logic [N_TAPS-1:0]       tap_strobe
);

    step_t            step;
    logic [CNT_W-1:0] rise;

    clkpre_prediv u_prediv (
        .clk      (clk),
        .rst      (rst),
        .mode     (pwr_mode_e'(pwr_mode)),
        .ratio_in (med_ratio),
        .step     (step)
    );

    clkpre_chain #(.CNT_W(CNT_W)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .rise (rise)
    );

    for (genvar p = 0; p < N_TAPS; p++) begin : g_tap
        clkpre_tap #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tap (
            .clk      (clk),
            .rst      (rst),
            .stopped  (step.stopped),
            .rise     (rise),
            .sel      (tap_sel[p*SEL_W +: SEL_W]),
            .strobe_q (tap_strobe[p])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (tap_strobe == '0)); // R2

endmodule

// File: tb/tb_clkpre_top.sv
module tb_clkpre_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 13;
    localparam int N_TAPS     = 4;
    localparam int SEL_W      = 4;
    localparam int WATCHDOG   = 150000;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [2:0]              pwr_mode = 3'd0;
    logic [1:0]              med_ratio = 2'd0;
    logic [N_TAPS*SEL_W-1:0] tap_sel = '0;
    logic [N_TAPS-1:0]       tap_strobe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R2";

    int m_cnt = 0;
    int m_pd = 0;
    int m_rat = 0;
    int m_old = 0;
    int m_sel = 0;
    bit m_adv = 0;
    bit [N_TAPS-1:0] m_exp = '0;

    clkpre_top #(.CNT_W(CNT_W), .N_TAPS(N_TAPS), .SEL_W(SEL_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .pwr_mode   (pwr_mode),
        .med_ratio  (med_ratio),
        .tap_sel    (tap_sel),
        .tap_strobe (tap_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: integer count, integer pre-divider, strobe
    // expected when the selected bit of the count goes 0 -> 1.
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pd = 0; m_rat = 0; m_exp = '0;
        end else if (pwr_mode >= 3) begin
            m_cnt = 0; m_pd = 0; m_rat = int'(med_ratio); m_exp = '0;
        end else begin
            if (pwr_mode == 0) begin
                m_adv = 1; m_pd = 0; m_rat = int'(med_ratio);
            end else if (m_pd == (16 << m_rat) - 1) begin
                m_adv = 1; m_pd = 0; m_rat = int'(med_ratio);
            end else begin
                m_adv = 0; m_pd = m_pd + 1;
            end
            m_old = m_cnt;
            if (m_adv) m_cnt = (m_cnt + 1) % (1 << CNT_W);
            for (int p = 0; p < N_TAPS; p++) begin
                m_sel = int'(tap_sel[p*SEL_W +: SEL_W]);
                m_exp[p] = m_adv && (m_sel < CNT_W) &&
                           (((m_old >> m_sel) & 1) == 0) &&
                           (((m_cnt >> m_sel) & 1) == 1);
            end
        end
    end

    always @(negedge clk) begin
        for (int p = 0; p < N_TAPS; p++) begin
            checks++;
            if (tap_strobe[p] !== m_exp[p]) begin
                errors++;
                $display("FAIL %s tap %0d cycle %0d: got %0b expected %0b",
                         cur_req, p, cycles, tap_strobe[p], m_exp[p]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic measure_gap(input int p, input int exp, input string req);
        int n;
        while (tap_strobe[p] !== 1'b1) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tap_strobe[p] !== 1'b1);
        check_val(req, n, exp);
    endtask

    task automatic first_strobe(input int p, input int exp, input string req);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tap_strobe[p] !== 1'b1 && n < 100000);
        check_val(req, n, exp);
    endtask

    initial begin
        // taps: 0 -> code 0, 1 -> code 2, 2 -> code 12, 3 -> code 14 (invalid)
        tap_sel = {4'd14, 4'd12, 4'd2, 4'd0};
        cur_req = "R2";
        run(4);
        check_val("R2", int'(tap_strobe), 0);
        rst = 1'b0;
        @(negedge clk);
        check_val("R2", int'(tap_strobe[0]), 1);

        cur_req = "R4";
        measure_gap(0, 2, "R4");
        measure_gap(1, 8, "R7");
        cur_req = "R1";
        run(9000);
        cur_req = "R9";
        run(200);

        cur_req = "R5";
        pwr_mode = 3'd1; med_ratio = 2'd0;
        measure_gap(0, 32, "R5");
        run(200);
        cur_req = "R6";
        med_ratio = 2'd2;
        run(1000);
        measure_gap(0, 128, "R6");

        cur_req = "R5";
        pwr_mode = 3'd2; med_ratio = 2'd3;
        run(300);
        measure_gap(0, 256, "R5");
        run(500);

        for (int m = 3; m <= 7; m++) begin
            cur_req = "R3";
            pwr_mode = 3'(m);
            run(40);
            check_val("R3", int'(tap_strobe), 0);
            cur_req = "R10";
            pwr_mode = 3'd0;
            first_strobe(1, 4, "R10");
            run(60);
        end

        cur_req = "R8";
        tap_sel = {4'd1, 4'd5, 4'd13, 4'd3};
        run(2000);
        cur_req = "R7";
        measure_gap(3, 4, "R7");
        measure_gap(2, 64, "R7");

        cur_req = "R2";
        rst = 1'b1;
        run(2);
        check_val("R2", int'(tap_strobe), 0);
        rst = 1'b0;
        run(100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule